// File: doc/BRIEF.md
# Packet Page Allocator and Queues

This block owns a small pool of fixed-size packet pages inside an Ethernet controller. A byte-wide register port lets software issue memory-manager commands: allocate a page for transmit, free a page, push a page onto the transmit queue, drop entries from the receive queue, or reset queues and the pool. The block keeps three queues of page numbers. The transmit queue feeds a transmit engine. The completion queue returns pages that have been sent. The receive queue holds pages that the receive side has filled.

A transmit allocate that finds no free page stays pending. It is granted as soon as a page becomes free. The receive side asks for pages through a single request line and gets its answer in the same cycle. Interrupt status bits follow the state of the queues and the allocator. A single interrupt line is the OR of the status bits that are enabled in the mask. A read of an empty queue head or of an unresolved allocation returns the sentinel value 0x80.

Register map (wr_addr / rd_addr):
- 0: command (write only)
- 1: packet number (read/write)
- 2: allocation result (read only)
- 3: completion-queue head (read only)
- 4: receive-queue head (read only)
- 5: status on read, acknowledge on write
- 6: mask (read/write)
- 7: control (read/write): bit 0 enables transmit, bit 1 enables auto-release

Status bits:
- bit 0 (0x01): receive pending
- bit 1 (0x02): completion queue not empty
- bit 2 (0x04): transmit queue empty
- bit 3 (0x08): allocation done
- bit 4 (0x10): receive overrun

Top module: `pkt_page_mgr`

## Requirements
- R1: An allocation takes the lowest-numbered free page of the 4-page pool. Register 2 holds the page number that was granted. When no page is free, register 2 reads 0x80.
- R2: The command is taken from bits 7:5 of a write to register 0. Bits 4:0 are ignored, and code 0 changes nothing.
- R3: Command 1 (allocate for transmit) clears status bit 3 and sets register 2 to 0x80 (pending). When a page is granted, register 2 takes the page number and status bit 3 is set. A pending allocate is granted on the cycle after a page is freed.
- R4: Status bit 2 is set whenever the transmit queue is empty. Status bit 1 is set whenever the completion queue is not empty.
- R5: irq is high exactly when (status AND mask) is nonzero.
- R6: A write to register 5 clears the status bits in (value AND 0xD6). Bits 0 and 3 are unaffected. If bit 1 of the value is set, the head of the completion queue is removed.
- R7: Command 3 drops the head of the receive queue. Command 4 drops it and frees its page. After a drop, status bit 0 is set if entries remain and cleared if the queue is empty.
- R8: A read of register 3 or register 4 returns 0x80 when the matching queue is empty.
- R9: On a tx_done pulse, the page is freed at once if control bit 1 is set. Otherwise it is pushed onto the completion queue, unless that queue is full.
- R10: Command 6 appends the packet-number register to the transmit queue. An append to a full queue (4 entries) is ignored. tx_valid is asserted only while control bit 0 is set and the queue holds an entry.
- R11: Command 2 frees every page, empties all three queues, cancels any pending allocate and sets register 2 to 0. After rst_n, status reads 0x04, mask reads 0 and register 2 reads 0.
- R12: A receive request takes the lowest free page ahead of a transmit allocate in the same cycle, pushes that page onto the receive queue and sets status bit 0. With no free page, rx_alloc_page is 0x80 and status bit 4 is set.
- R13: Command 7 empties the transmit and completion queues and leaves page ownership unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| rx_alloc_req | input | 1 | Receive side requests a page |
| rx_alloc_page | output | 8 | Granted page number, or 0x80 when none is free |
| tx_valid | output | 1 | Transmit queue head is offered |
| tx_page | output | 2 | Page number at the head of the transmit queue |
| tx_ready | input | 1 | Transmit engine accepts the head |
| tx_done | input | 1 | One-cycle pulse: a page has finished sending |
| tx_done_page | input | 2 | Page number that has finished |
| irq | output | 1 | Interrupt line |

## Verification
Assertions check on every cycle that a pending allocate always reads as the sentinel, and that the transmit-empty and completion status bits agree with the queue state. They also check that queue occupancy stays within its depth, that the two grants of one cycle never hand out the same page, and that a transmit grant in a cycle with a receive request implies the receive side was served. Only the directed scenarios can show the values seen at the ports. These are the lowest-free ordering, retry after a release, acknowledge masking, the receive drop and free sequence, auto-release versus completion queueing, the ignored fifth append, and the effects of a flush and a manager reset.

// File: rtl/pkt_page_pkg.sv
package pkt_page_pkg;

  typedef enum logic [2:0] {
    CMD_NOP      = 3'd0,
    CMD_ALLOC_TX = 3'd1,
    CMD_MGR_RST  = 3'd2,
    CMD_RX_DROP  = 3'd3,
    CMD_RX_FREE  = 3'd4,
    CMD_REL_PNUM = 3'd5,
    CMD_TX_PUSH  = 3'd6,
    CMD_TX_FLUSH = 3'd7
  } mgr_cmd_e;

  localparam logic [3:0] A_CMD   = 4'd0;
  localparam logic [3:0] A_PNUM  = 4'd1;
  localparam logic [3:0] A_ARES  = 4'd2;
  localparam logic [3:0] A_DONEH = 4'd3;
  localparam logic [3:0] A_RXH   = 4'd4;
  localparam logic [3:0] A_STAT  = 4'd5;
  localparam logic [3:0] A_MASK  = 4'd6;
  localparam logic [3:0] A_CTRL  = 4'd7;

  localparam int ST_RCV   = 0;
  localparam int ST_TX    = 1;
  localparam int ST_TXEMP = 2;
  localparam int ST_ALLOC = 3;
  localparam int ST_OVRN  = 4;

  localparam logic [7:0] NONE_SENTINEL = 8'h80;
  localparam logic [7:0] ACK_CLEARABLE = 8'hD6;
  localparam logic [7:0] STAT_RESET    = 8'h04;

  // status bits cleared by an acknowledge value
  function automatic logic [7:0] ack_clear_bits(input logic [7:0] v);
    return v & ACK_CLEARABLE;
  endfunction

endpackage

// File: rtl/page_queue.sv
module page_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         empty_nxt
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign head    = mem[rp_q];

  always_comb begin
    if (flush) cnt_n = '0;
    else cnt_n = cnt_q + CNT_W'(do_push) - CNT_W'(do_pop);
  end
  assign empty_nxt = (cnt_n == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      if (flush) begin
        wp_q <= '0;
        rp_q <= '0;
      end else begin
        if (do_push) wp_q <= ptr_inc(wp_q);
        if (do_pop)  rp_q <= ptr_inc(rp_q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end

  // R10
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/page_pool.sv
module page_pool #(
  parameter int NPAGES = 4,
  parameter int PW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              req_a,
  input  logic              req_b,
  input  logic [NPAGES-1:0] rel_mask,
  output logic              gnt_a,
  output logic [PW-1:0]     page_a,
  output logic              gnt_b,
  output logic [PW-1:0]     page_b
);
  logic [NPAGES-1:0] used_q, used_n, free_a, free_b;

  function automatic logic [PW-1:0] lowest_free(input logic [NPAGES-1:0] f);
    logic [PW-1:0] r;
    r = '0;
    for (int i = NPAGES - 1; i >= 0; i--) if (f[i]) r = PW'(i);
    return r;
  endfunction

  function automatic logic [NPAGES-1:0] page_bit(input logic [PW-1:0] p);
    return NPAGES'(1) << p;
  endfunction

  assign free_a = ~used_q;
  assign page_a = lowest_free(free_a);
  assign gnt_a  = req_a && (|free_a);
  assign free_b = free_a & ~(gnt_a ? page_bit(page_a) : '0);
  assign page_b = lowest_free(free_b);
  assign gnt_b  = req_b && (|free_b);

  always_comb begin
    used_n = used_q & ~rel_mask;
    if (gnt_a) used_n = used_n | page_bit(page_a);
    if (gnt_b) used_n = used_n | page_bit(page_b);
    if (clear) used_n = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= used_n;
  end

  // R12
  distinct_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_a && gnt_b) |-> (page_a != page_b));

  // R1
  grant_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_b && !clear) |=> used_q[$past(page_b)]);

endmodule

// File: rtl/pkt_page_mgr.sv
module pkt_page_mgr
  import pkt_page_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  parameter int PAGE_W    = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [3:0]        rd_addr,
  output logic [7:0]        rd_data,
  input  logic              rx_alloc_req,
  output logic [7:0]        rx_alloc_page,
  output logic              tx_valid,
  output logic [PAGE_W-1:0] tx_page,
  input  logic              tx_ready,
  input  logic              tx_done,
  input  logic [PAGE_W-1:0] tx_done_page,
  output logic              irq
);
  localparam int PAD = 8 - PAGE_W;

  function automatic logic [7:0] widen(input logic [PAGE_W-1:0] p);
    return {{PAD{1'b0}}, p};
  endfunction

  function automatic logic [NUM_PAGES-1:0] onehot(input logic [PAGE_W-1:0] p);
    return NUM_PAGES'(1) << p;
  endfunction

  logic [PAGE_W-1:0] pnum_q;
  logic [7:0]        ares_q, stat_q, stat_n, mask_q;
  logic [1:0]        ctrl_q;
  logic              pend_q;

  logic     cmd_wr, ack_wr;
  mgr_cmd_e cmd;
  logic     mgr_clear, tx_flush, alloc_cmd, rx_pop, rx_free, rel_pnum, tx_push;
  logic     tx_en, auto_rel;

  logic              gnt_a, gnt_b;
  logic [PAGE_W-1:0] page_a, page_b;
  logic [NUM_PAGES-1:0] rel_mask;

  logic [PAGE_W-1:0] rxq_head, txq_head, dnq_head;
  logic rxq_empty, rxq_full, rxq_empty_nxt;
  logic txq_empty, txq_full, txq_empty_nxt;
  logic dnq_empty, dnq_full, dnq_empty_nxt;
  logic tx_take, done_push, done_pop;

  // command decode
  assign cmd_wr    = wr_en && (wr_addr == A_CMD);
  assign ack_wr    = wr_en && (wr_addr == A_STAT);
  assign cmd       = mgr_cmd_e'(wr_data[7:5]);
  assign mgr_clear = cmd_wr && (cmd == CMD_MGR_RST);
  assign tx_flush  = cmd_wr && (cmd == CMD_TX_FLUSH);
  assign alloc_cmd = cmd_wr && (cmd == CMD_ALLOC_TX);
  assign rx_free   = cmd_wr && (cmd == CMD_RX_FREE);
  assign rx_pop    = cmd_wr && ((cmd == CMD_RX_DROP) || (cmd == CMD_RX_FREE));
  assign rel_pnum  = cmd_wr && (cmd == CMD_REL_PNUM);
  assign tx_push   = cmd_wr && (cmd == CMD_TX_PUSH);
  assign tx_en     = ctrl_q[0];
  assign auto_rel  = ctrl_q[1];

  // page releases of this cycle
  always_comb begin
    rel_mask = '0;
    if (rel_pnum)                rel_mask = rel_mask | onehot(pnum_q);
    if (rx_free && !rxq_empty)   rel_mask = rel_mask | onehot(rxq_head);
    if (tx_done && auto_rel)     rel_mask = rel_mask | onehot(tx_done_page);
  end

  page_pool #(.NPAGES(NUM_PAGES), .PW(PAGE_W)) u_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (mgr_clear),
    .req_a    (rx_alloc_req && !mgr_clear),
    .req_b    ((alloc_cmd || pend_q) && !mgr_clear),
    .rel_mask (rel_mask),
    .gnt_a    (gnt_a),
    .page_a   (page_a),
    .gnt_b    (gnt_b),
    .page_b   (page_b)
  );

  assign rx_alloc_page = gnt_a ? widen(page_a) : NONE_SENTINEL;

  page_queue #(.DEPTH(NUM_PAGES), .W(PAGE_W)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(mgr_clear),
    .push(gnt_a), .push_data(page_a), .pop(rx_pop),
    .head(rxq_head), .empty(rxq_empty), .full(rxq_full), .empty_nxt(rxq_empty_nxt)
  );

  assign tx_valid = tx_en && !txq_empty;
  assign tx_page  = txq_head;
  assign tx_take  = tx_valid && tx_ready;

  page_queue #(.DEPTH(NUM_PAGES), .W(PAGE_W)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(mgr_clear || tx_flush),
    .push(tx_push), .push_data(pnum_q), .pop(tx_take),
    .head(txq_head), .empty(txq_empty), .full(txq_full), .empty_nxt(txq_empty_nxt)
  );

  assign done_push = tx_done && !auto_rel;
  assign done_pop  = ack_wr && wr_data[ST_TX];

  page_queue #(.DEPTH(NUM_PAGES), .W(PAGE_W)) u_dnq (
    .clk(clk), .rst_n(rst_n), .flush(mgr_clear || tx_flush),
    .push(done_push), .push_data(tx_done_page), .pop(done_pop),
    .head(dnq_head), .empty(dnq_empty), .full(dnq_full), .empty_nxt(dnq_empty_nxt)
  );

  // status next state
  always_comb begin
    stat_n = stat_q;
    if (ack_wr) stat_n = stat_n & ~ack_clear_bits(wr_data);
    if (alloc_cmd) stat_n[ST_ALLOC] = 1'b0;
    if (gnt_b)     stat_n[ST_ALLOC] = 1'b1;
    if (gnt_a || rx_pop) stat_n[ST_RCV] = !rxq_empty_nxt;
    if (rx_alloc_req && !gnt_a && !mgr_clear) stat_n[ST_OVRN] = 1'b1;
    if (txq_empty_nxt)  stat_n[ST_TXEMP] = 1'b1;
    if (!dnq_empty_nxt) stat_n[ST_TX]    = 1'b1;
    stat_n[7:5] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pnum_q <= '0;
      ares_q <= '0;
      pend_q <= 1'b0;
      stat_q <= STAT_RESET;
      mask_q <= '0;
      ctrl_q <= '0;
    end else begin
      stat_q <= stat_n;
      if (wr_en && wr_addr == A_PNUM) pnum_q <= wr_data[PAGE_W-1:0];
      if (wr_en && wr_addr == A_MASK) mask_q <= wr_data;
      if (wr_en && wr_addr == A_CTRL) ctrl_q <= wr_data[1:0];
      if (mgr_clear) begin
        ares_q <= '0;
        pend_q <= 1'b0;
      end else if (gnt_b) begin
        ares_q <= widen(page_b);
        pend_q <= 1'b0;
      end else if (alloc_cmd) begin
        ares_q <= NONE_SENTINEL;
        pend_q <= 1'b1;
      end
    end
  end

  assign irq = |(stat_q & mask_q);

  always_comb begin
    case (rd_addr)
      A_PNUM:  rd_data = widen(pnum_q);
      A_ARES:  rd_data = ares_q;
      A_DONEH: rd_data = dnq_empty ? NONE_SENTINEL : widen(dnq_head);
      A_RXH:   rd_data = rxq_empty ? NONE_SENTINEL : widen(rxq_head);
      A_STAT:  rd_data = stat_q;
      A_MASK:  rd_data = mask_q;
      A_CTRL:  rd_data = {6'd0, ctrl_q};
      default: rd_data = '0;
    endcase
  end

  // R3
  pending_sentinel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (ares_q == NONE_SENTINEL));

  // R4
  tx_empty_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txq_empty |-> stat_q[ST_TXEMP]);

  // R4
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dnq_empty |-> stat_q[ST_TX]);

  // R12
  rx_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_alloc_req && gnt_b) |-> gnt_a);

  // R10
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !tx_flush && !mgr_clear && !(wr_en && wr_addr == A_CTRL))
      |=> (tx_valid && $stable(tx_page)));

endmodule

// File: tb/test_pkt_page_mgr.sv
`timescale 1ns/1ps
module test_pkt_page_mgr;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       rx_alloc_req = 1'b0;
  logic [7:0] rx_alloc_page;
  logic       tx_valid;
  logic [1:0] tx_page;
  logic       tx_ready = 1'b0;
  logic       tx_done = 1'b0;
  logic [1:0] tx_done_page = '0;
  logic       irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pkt_page_mgr i_pkt_page_mgr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .rx_alloc_req(rx_alloc_req),
    .rx_alloc_page(rx_alloc_page), .tx_valid(tx_valid), .tx_page(tx_page),
    .tx_ready(tx_ready), .tx_done(tx_done), .tx_done_page(tx_done_page), .irq(irq)
  );

  localparam logic [7:0] NOP = 8'h00, ALLOC = 8'h20, MRST = 8'h40, RXDROP = 8'h60,
                         RXFREE = 8'h80, REL = 8'hA0, PUSH = 8'hC0, FLUSH = 8'hE0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    rd_addr = a;
    #0.1;
    d = rd_data;
  endtask

  task automatic rx_req();
    @(negedge clk);
    rx_alloc_req = 1'b1;
    @(negedge clk);
    rx_alloc_req = 1'b0;
  endtask

  task automatic done_pulse(input logic [1:0] p);
    @(negedge clk);
    tx_done = 1'b1; tx_done_page = p;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(4'd5, v); chk("R11 status after reset", v, 8'h04);
    rd(4'd6, v); chk("R11 mask after reset", v, 8'h00);
    rd(4'd2, v); chk("R11 alloc result after reset", v, 8'h00);
    rd(4'd3, v); chk("R8 empty done head", v, 8'h80);
    rd(4'd4, v); chk("R8 empty rx head", v, 8'h80);
    chk("R5 irq after reset", {7'd0, irq}, 8'h00);
    chk("R10 no tx_valid after reset", {7'd0, tx_valid}, 8'h00);
  endtask

  task automatic t_alloc();
    logic [7:0] v;
    for (int i = 0; i < 4; i++) begin
      wr(4'd0, ALLOC);
      rd(4'd2, v); chk("R1 lowest free page", v, 8'(i));
    end
    rd(4'd5, v); chk("R3 alloc bit set", v & 8'h08, 8'h08);
    wr(4'd0, 8'h1F);
    rd(4'd2, v); chk("R2 low bits ignored, no-op", v, 8'h03);
    wr(4'd0, ALLOC);
    rd(4'd2, v); chk("R1 pool exhausted sentinel", v, 8'h80);
    rd(4'd5, v); chk("R3 alloc bit cleared while pending", v & 8'h08, 8'h00);
    wr(4'd1, 8'h02);
    wr(4'd0, REL);
    @(negedge clk);
    rd(4'd2, v); chk("R3 pending retried after release", v, 8'h02);
    rd(4'd5, v); chk("R3 alloc bit set by retry", v & 8'h08, 8'h08);
  endtask

  task automatic t_irq();
    wr(4'd6, 8'h08);
    chk("R5 irq on masked alloc bit", {7'd0, irq}, 8'h01);
    wr(4'd6, 8'h10);
    chk("R5 irq low when mask misses", {7'd0, irq}, 8'h00);
    wr(4'd6, 8'h00);
  endtask

  task automatic t_mgr_reset();
    logic [7:0] v;
    wr(4'd0, MRST);
    rd(4'd2, v); chk("R11 manager reset result", v, 8'h00);
    wr(4'd0, ALLOC);
    rd(4'd2, v); chk("R11 pages freed by manager reset", v, 8'h00);
  endtask

  task automatic t_tx_path();
    logic [7:0] v;
    wr(4'd0, MRST);
    wr(4'd0, ALLOC);
    wr(4'd1, 8'h00);
    wr(4'd0, PUSH);
    chk("R10 no tx_valid while disabled", {7'd0, tx_valid}, 8'h00);
    wr(4'd5, 8'h04);
    rd(4'd5, v); chk("R6 ack clears tx-empty bit", v & 8'h04, 8'h00);
    wr(4'd7, 8'h01);
    chk("R10 tx_valid with enable", {7'd0, tx_valid}, 8'h01);
    chk("R10 tx_page head", {6'd0, tx_page}, 8'h00);
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
    chk("R10 queue drained", {7'd0, tx_valid}, 8'h00);
    rd(4'd5, v); chk("R4 tx-empty bit back", v & 8'h04, 8'h04);
    done_pulse(2'd0);
    rd(4'd3, v); chk("R9 page on completion queue", v, 8'h00);
    rd(4'd5, v); chk("R4 completion bit set", v & 8'h02, 8'h02);
    wr(4'd5, 8'h02);
    rd(4'd3, v); chk("R6 ack pops completion queue", v, 8'h80);
    rd(4'd5, v); chk("R6 completion bit cleared", v & 8'h02, 8'h00);
    wr(4'd7, 8'h03);
    wr(4'd0, ALLOC);
    rd(4'd2, v); chk("R1 next free page", v, 8'h01);
    done_pulse(2'd1);
    rd(4'd3, v); chk("R9 auto-release skips completion queue", v, 8'h80);
    wr(4'd0, ALLOC);
    rd(4'd2, v); chk("R9 auto-release freed page", v, 8'h01);
    wr(4'd7, 8'h00);
  endtask

  task automatic t_tx_full();
    wr(4'd0, MRST);
    for (int i = 0; i < 4; i++) begin
      wr(4'd1, 8'(i));
      wr(4'd0, PUSH);
    end
    wr(4'd1, 8'h01);
    wr(4'd0, PUSH);
    wr(4'd7, 8'h01);
    @(negedge clk);
    tx_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      chk("R10 tx_valid in order", {7'd0, tx_valid}, 8'h01);
      chk("R10 tx order", {6'd0, tx_page}, 8'(i));
      @(negedge clk);
    end
    chk("R10 fifth append ignored", {7'd0, tx_valid}, 8'h00);
    tx_ready = 1'b0;
    wr(4'd7, 8'h00);
  endtask

  task automatic t_flush();
    logic [7:0] v;
    wr(4'd0, MRST);
    wr(4'd1, 8'h02);
    wr(4'd0, PUSH);
    done_pulse(2'd3);
    rd(4'd3, v); chk("R9 completion head before flush", v, 8'h03);
    wr(4'd0, FLUSH);
    rd(4'd3, v); chk("R13 completion queue flushed", v, 8'h80);
    wr(4'd7, 8'h01);
    chk("R13 transmit queue flushed", {7'd0, tx_valid}, 8'h00);
    wr(4'd7, 8'h00);
  endtask

  task automatic t_rx();
    logic [7:0] v;
    wr(4'd0, MRST);
    wr(4'd5, 8'hFF);
    @(negedge clk);
    rx_alloc_req = 1'b1;
    #0.1;
    chk("R12 rx page granted", rx_alloc_page, 8'h00);
    @(negedge clk);
    rx_alloc_req = 1'b0;
    rd(4'd4, v); chk("R12 rx queue head", v, 8'h00);
    rd(4'd5, v); chk("R12 rcv bit set", v & 8'h01, 8'h01);
    rx_req();
    wr(4'd5, 8'hFF);
    rd(4'd5, v); chk("R6 rcv bit not ackable", v & 8'h01, 8'h01);
    wr(4'd0, RXDROP);
    rd(4'd4, v); chk("R7 drop advances head", v, 8'h01);
    rd(4'd5, v); chk("R7 rcv stays with entries", v & 8'h01, 8'h01);
    wr(4'd0, RXFREE);
    rd(4'd4, v); chk("R7 rx queue empty", v, 8'h80);
    rd(4'd5, v); chk("R7 rcv cleared", v & 8'h01, 8'h00);
    wr(4'd0, ALLOC);
    rd(4'd2, v); chk("R7 freed page reused", v, 8'h01);
  endtask

  task automatic t_priority();
    logic [7:0] v;
    wr(4'd0, MRST);
    for (int i = 0; i < 3; i++) wr(4'd0, ALLOC);
    @(negedge clk);
    rx_alloc_req = 1'b1;
    wr_en = 1'b1; wr_addr = 4'd0; wr_data = ALLOC;
    #0.1;
    chk("R12 rx wins last page", rx_alloc_page, 8'h03);
    @(negedge clk);
    rx_alloc_req = 1'b0; wr_en = 1'b0;
    rd(4'd2, v); chk("R12 tx allocate pending", v, 8'h80);
    @(negedge clk);
    rx_alloc_req = 1'b1;
    #0.1;
    chk("R12 no page sentinel", rx_alloc_page, 8'h80);
    @(negedge clk);
    rx_alloc_req = 1'b0;
    rd(4'd5, v); chk("R12 overrun bit", v & 8'h10, 8'h10);
    wr(4'd5, 8'h10);
    rd(4'd5, v); chk("R6 overrun acked", v & 8'h10, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alloc();
    t_irq();
    t_mgr_reset();
    t_tx_path();
    t_tx_full();
    t_flush();
    t_rx();
    t_priority();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule